// File: doc/BRIEF.md
# Pulse-and-Verify Word Programming Sequencer

The block programs a one-time-programmable memory one word at a time. After a start request it requests the elevated programming supply and begins at the first address. For each word it holds address and data steady, applies a fixed-width active-low program strobe and then reads the word back. It repeats the strobe until the readback equals the expected word or the per-word pulse budget runs out. Words are handled in ascending order. When the last word has been accepted, the supply request drops back to nominal and a second sweep reads every address once and compares it. The outcome is reported as a one-cycle completion strobe and a held pass or fail flag.

The expected word comes from an outside data source that is indexed by the same address the sequencer drives to the memory. The source must return the word combinationally. Supply control is reduced to a single request output. Pulse width, settle time, word count and pulse budget are all parameters counted in clock cycles.

Top module: `otp_prog_seq`

## Requirements
- R1: While reset is held and after it releases, `mem_pgm_n_o` and `mem_oe_n_o` are 1, and `vpp_req_o`, `done_o`, `pass_o` and `fail_o` are 0.
- R2: A start accepted in idle clears `pass_o`/`fail_o` in the next cycle, drives address 0, raises `vpp_req_o` and begins the first word with its pulse count at zero.
- R3: Each attempt holds address and data for SETTLE_CYC cycles with both strobes at 1, then drives `mem_pgm_n_o` to 0 for exactly PULSE_CYC cycles. `vpp_req_o` stays 1 throughout, and the address does not change while the strobe is low.
- R4: After each pulse, `mem_oe_n_o` is 0 for SETTLE_CYC cycles. On the last of those cycles, all DATA_W bits of `mem_rdata_i` are compared with `exp_word_i`.
- R5: A word that fails its compare gets another attempt (R3) at the same address. If the compare fails after pulse number MAX_PULSES, the run ends with `fail_o`=1 and no further pulse is issued.
- R6: A word that compares equal moves the run to the next address, with the pulse count reset to zero.
- R7: After the last address is accepted, `vpp_req_o` drops to 0 and each address from 0 to N_WORDS-1 is read with `mem_oe_n_o`=0 for SETTLE_CYC cycles. The first mismatch ends the run with `fail_o`=1.
- R8: If every address of the final sweep compares equal, the run ends with `pass_o`=1 and `fail_o`=0.
- R9: The end of a run is marked by `done_o`=1 for exactly one cycle, with `vpp_req_o`=0 and both strobes at 1. `pass_o`/`fail_o` keep their value until the next accepted start.
- R10: A start raised while a run is in progress has no effect on the strobes, the address or the result.
- R11: `mem_pgm_n_o` and `mem_oe_n_o` are never both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start request, sampled in idle only |
| addr_o | output | ADDR_W | Word address to memory and data source |
| exp_word_i | input | DATA_W | Expected word for `addr_o` from the data source |
| mem_wdata_o | output | DATA_W | Data presented to the memory for programming |
| mem_rdata_i | input | DATA_W | Readback word from the memory |
| mem_pgm_n_o | output | 1 | Active-low program strobe |
| mem_oe_n_o | output | 1 | Active-low read/output enable |
| vpp_req_o | output | 1 | 1 requests elevated programming supply, 0 nominal |
| done_o | output | 1 | One-cycle run-complete strobe |
| pass_o | output | 1 | Held device-passed result |
| fail_o | output | 1 | Held device-failed result |

## Verification
The assertions assume that `exp_word_i` follows `addr_o` within the same cycle. They also assume that `mem_rdata_i` is settled by the last cycle of every read window. They rely on the memory model holding state between pulses, so no word changes except as a result of pulses to that word or the bench's deliberate nominal-supply disturbance. The bench memory returns its word combinationally from state updated away from the clock edge. It counts strobes per address and makes each word match only after a chosen number of pulses. The pulse counts and disturbed addresses are chosen so that every exit path is reached: a clean pass, retries up to exactly the budget, one pulse beyond the budget, and a final-sweep mismatch. Start pulses sent during a run are only ever sent while the sequencer is busy.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_PULSE = 3'd2,
    ST_VWAIT = 3'd3,
    ST_FCHK  = 3'd4
  } seq_st_e;
endpackage

// File: rtl/otp_seq_counter.sv
module otp_seq_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_o;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_o <= '0;
    else        cnt_o <= cnt_d;
  end
endmodule

// File: rtl/otp_seq_match.sv
module otp_seq_match #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              eq_o
);
  localparam int LANES = (DATA_W + LANE_W - 1) / LANE_W;

  logic [LANES-1:0] lane_eq;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LO = g * LANE_W;
    localparam int HI = (LO + LANE_W > DATA_W) ? DATA_W - 1 : LO + LANE_W - 1;
    assign lane_eq[g] = (a_i[HI:LO] == b_i[HI:LO]);
  end

  assign eq_o = &lane_eq;
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_seq_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int N_WORDS    = 8,
  parameter int PULSE_CYC  = 16,
  parameter int SETTLE_CYC = 4,
  parameter int MAX_PULSES = 25,
  localparam int ADDR_W    = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic [ADDR_W-1:0] addr_o,
  input  logic [DATA_W-1:0] exp_word_i,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_pgm_n_o,
  output logic              mem_oe_n_o,
  output logic              vpp_req_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o
);
  localparam int TMAX  = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
  localparam int TMR_W = $clog2(TMAX + 1);
  localparam int NP_W  = $clog2(MAX_PULSES + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR  = ADDR_W'(N_WORDS - 1);
  localparam logic [TMR_W-1:0]  PULSE_LAST = TMR_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0]  SETL_LAST  = TMR_W'(SETTLE_CYC - 1);
  localparam logic [NP_W-1:0]   NP_LIMIT   = NP_W'(MAX_PULSES);

  seq_st_e           st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              done_q, done_d;
  logic              pass_q, pass_d;
  logic              fail_q, fail_d;
  logic [TMR_W-1:0]  tmr;
  logic              tmr_term, tmr_clr;
  logic [NP_W-1:0]   npulse;
  logic              np_clr, np_inc;
  logic              word_ok;

  // cycle timer for setup, pulse and read windows
  assign tmr_term = (st_q == ST_PULSE) ? (tmr == PULSE_LAST) : (tmr == SETL_LAST);
  assign tmr_clr  = (st_q == ST_IDLE) || tmr_term;

  otp_seq_counter #(.W(TMR_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .en    (1'b1),
    .cnt_o (tmr)
  );

  // pulses applied to the current word
  assign np_inc = (st_q == ST_PULSE) && tmr_term;

  otp_seq_counter #(.W(NP_W)) u_npulse (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (np_clr),
    .en    (np_inc),
    .cnt_o (npulse)
  );

  otp_seq_match #(.DATA_W(DATA_W), .LANE_W(8)) u_match (
    .a_i  (mem_rdata_i),
    .b_i  (exp_word_i),
    .eq_o (word_ok)
  );

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    done_d = 1'b0;
    pass_d = pass_q;
    fail_d = fail_q;
    np_clr = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_SETUP;
          addr_d = '0;
          pass_d = 1'b0;
          fail_d = 1'b0;
          np_clr = 1'b1;
        end
      end
      ST_SETUP: if (tmr_term) st_d = ST_PULSE;
      ST_PULSE: if (tmr_term) st_d = ST_VWAIT;
      ST_VWAIT: begin
        if (tmr_term) begin
          if (word_ok) begin
            np_clr = 1'b1;
            if (addr_q == LAST_ADDR) begin
              st_d   = ST_FCHK;
              addr_d = '0;
            end else begin
              st_d   = ST_SETUP;
              addr_d = addr_q + 1'b1;
            end
          end else if (npulse == NP_LIMIT) begin
            st_d   = ST_IDLE;
            fail_d = 1'b1;
            done_d = 1'b1;
          end else begin
            st_d = ST_SETUP;
          end
        end
      end
      ST_FCHK: begin
        if (tmr_term) begin
          if (!word_ok) begin
            st_d   = ST_IDLE;
            fail_d = 1'b1;
            done_d = 1'b1;
          end else if (addr_q == LAST_ADDR) begin
            st_d   = ST_IDLE;
            pass_d = 1'b1;
            done_d = 1'b1;
          end else begin
            addr_d = addr_q + 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      done_q <= done_d;
      pass_q <= pass_d;
      fail_q <= fail_d;
    end
  end

  assign addr_o      = addr_q;
  assign mem_wdata_o = exp_word_i;
  assign mem_pgm_n_o = (st_q != ST_PULSE);
  assign mem_oe_n_o  = !((st_q == ST_VWAIT) || (st_q == ST_FCHK));
  assign vpp_req_o   = (st_q == ST_SETUP) || (st_q == ST_PULSE) || (st_q == ST_VWAIT);
  assign done_o      = done_q;
  assign pass_o      = pass_q;
  assign fail_o      = fail_q;
endmodule

// File: rtl/otp_prog_seq_chk.sv
module otp_prog_seq_chk #(
  parameter int PULSE_CYC  = 16,
  parameter int MAX_PULSES = 25,
  parameter int ADDR_W     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_o,
  input logic              mem_pgm_n_o,
  input logic              mem_oe_n_o,
  input logic              vpp_req_o,
  input logic              done_o,
  input logic              pass_o,
  input logic              fail_o
);
  int                low_cnt;
  int                pcnt;
  logic              pgm_n_d;
  logic [ADDR_W-1:0] pulse_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt    <= 0;
      pcnt       <= 0;
      pgm_n_d    <= 1'b1;
      pulse_addr <= '0;
    end else begin
      pgm_n_d <= mem_pgm_n_o;
      low_cnt <= mem_pgm_n_o ? 0 : low_cnt + 1;
      if (done_o) begin
        pcnt <= 0;
      end else if (!mem_pgm_n_o && pgm_n_d) begin
        pcnt       <= (addr_o == pulse_addr) ? pcnt + 1 : 1;
        pulse_addr <= addr_o;
      end
    end
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_pgm_n_o) |-> (low_cnt == PULSE_CYC)); // R3
  AST_PGM_NEEDS_VPP: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_pgm_n_o |-> vpp_req_o); // R3
  AST_ADDR_HELD_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_pgm_n_o |-> $stable(addr_o)); // R3
  AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= MAX_PULSES); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_pgm_n_o && !mem_oe_n_o)); // R11
  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_VERDICT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pass_o) || $rose(fail_o)) |-> done_o); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!vpp_req_o && mem_pgm_n_o && mem_oe_n_o)); // R9
endmodule

bind otp_prog_seq otp_prog_seq_chk #(
  .PULSE_CYC  (PULSE_CYC),
  .MAX_PULSES (MAX_PULSES),
  .ADDR_W     (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr_o      (addr_o),
  .mem_pgm_n_o (mem_pgm_n_o),
  .mem_oe_n_o  (mem_oe_n_o),
  .vpp_req_o   (vpp_req_o),
  .done_o      (done_o),
  .pass_o      (pass_o),
  .fail_o      (fail_o)
);

// File: tb/sim_otp_prog_seq.sv
module sim_otp_prog_seq;
  localparam int DW  = 16;
  localparam int NW  = 6;
  localparam int PC  = 4;
  localparam int SC  = 2;
  localparam int MXP = 25;
  localparam int AW  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] addr;
  logic [DW-1:0] exp_w, wdata, rdata;
  logic          pgm_n, oe_n, vpp, done, pass, fail;

  int checks = 0;
  int errs   = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  otp_prog_seq #(
    .DATA_W(DW), .N_WORDS(NW), .PULSE_CYC(PC), .SETTLE_CYC(SC), .MAX_PULSES(MXP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .addr_o(addr),
    .exp_word_i(exp_w), .mem_wdata_o(wdata), .mem_rdata_i(rdata),
    .mem_pgm_n_o(pgm_n), .mem_oe_n_o(oe_n), .vpp_req_o(vpp),
    .done_o(done), .pass_o(pass), .fail_o(fail)
  );

  function automatic logic [DW-1:0] word_of(input int a);
    return 16'hA5C3 ^ DW'(a * 16'h1357);
  endfunction

  assign exp_w = word_of(int'(addr));

  // memory model: a word reads back correct only after need[a] pulses
  int   need[NW];
  int   pulses[NW];
  int   dist_a = -1;
  logic pgm_prev = 1'b1;

  always @(negedge clk) begin
    if (!pgm_n && pgm_prev) pulses[addr] = pulses[addr] + 1;
    pgm_prev = pgm_n;
    if (pulses[addr] >= need[addr])
      rdata = word_of(int'(addr)) ^ ((!vpp && int'(addr) == dist_a) ? 16'h0001 : 16'h0000);
    else
      rdata = 16'hFFFF;
  end

  // expected trace: one entry per cycle
  int         q_addr[$];
  logic [5:0] q_ctl[$];   // {pgm_n, oe_n, vpp, done, pass, fail}
  string      q_tag[$];

  task automatic push(input int a, input logic [5:0] c, input string t);
    q_addr.push_back(a);
    q_ctl.push_back(c);
    q_tag.push_back(t);
  endtask

  task automatic build();
    bit bad = 0;
    for (int a = 0; a < NW && !bad; a++) begin
      for (int k = 1; k <= MXP; k++) begin
        for (int i = 0; i < SC; i++)
          push(a, 6'b111000, (k == 1 && i == 0) ? ((a == 0) ? "R2" : "R6") : "R3");
        for (int i = 0; i < PC; i++) push(a, 6'b011000, "R3");
        for (int i = 0; i < SC; i++) push(a, 6'b101000, (k > 1) ? "R5" : "R4");
        if (k >= need[a]) break;
        if (k == MXP) begin bad = 1; break; end
      end
    end
    if (bad) begin
      push(-1, 6'b110101, "R5");
    end else begin
      for (int a = 0; a < NW && !bad; a++) begin
        for (int i = 0; i < SC; i++) push(a, 6'b100000, "R7");
        if (a == dist_a) bad = 1;
      end
      if (bad) push(-1, 6'b110101, "R7");
      else     push(-1, 6'b110110, "R8");
    end
    for (int i = 0; i < 3; i++) push(-1, bad ? 6'b110001 : 6'b110010, "R9");
  endtask

  task automatic cmp_one();
    int         ea = q_addr.pop_front();
    logic [5:0] ec = q_ctl.pop_front();
    string      t  = q_tag.pop_front();
    logic [5:0] ac = {pgm_n, oe_n, vpp, done, pass, fail};
    checks++;
    if (ac !== ec || (ea >= 0 && int'(addr) != ea)) begin
      errs++;
      $display("FAIL %s: ctl=%b addr=%0d expected ctl=%b addr=%0d", t, ac, addr, ec, ea);
    end
    checks++; // R11
    if (!pgm_n && !oe_n) begin
      errs++;
      $display("FAIL R11: pgm_n=%b oe_n=%b expected not both 0", pgm_n, oe_n);
    end
  endtask

  task automatic run(input bit poke);
    int n = 0;
    for (int a = 0; a < NW; a++) pulses[a] = 0;
    build();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (q_ctl.size() > 0) begin
      cmp_one();
      n++;
      // R10: start while busy must leave the trace unchanged
      start = poke && (n == 10 || n == 41);
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  task automatic chk_idle(input string t);
    checks++;
    if ({pgm_n, oe_n, vpp, done, pass, fail} !== 6'b110000) begin
      errs++;
      $display("FAIL %s: ctl=%b expected ctl=110000", t, {pgm_n, oe_n, vpp, done, pass, fail});
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errs++;
      $display("FAIL watchdog: cycles=%0d expected under 100000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < NW; a++) begin need[a] = 1; pulses[a] = 0; end
    rdata = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_idle("R1");

    // clean pass, one pulse per word (R2 R3 R4 R6 R7 R8 R9)
    run(1'b0);

    // retries, including a word needing exactly the budget (R5 R6 R8), busy pokes (R10)
    need = '{1, 3, 25, 2, 1, 4};
    run(1'b1);

    // a word that never verifies within the budget (R5)
    need = '{1, 2, 1, 26, 1, 1};
    run(1'b0);

    // final sweep mismatch at the last address (R7)
    need = '{1, 1, 1, 1, 1, 1};
    dist_a = NW - 1;
    run(1'b0);

    // final sweep mismatch at the first address (R7)
    dist_a = 0;
    run(1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule